// File: doc/BRIEF.md
# Strap-Latched Clock Configuration Controller

This block decides the operating state of a system clock generator. When reset is released it samples the configuration pins once. From them it derives four fields: the processor frequency code, the 33/66 MHz select for the switchable output group, the 24/48 MHz select for the auxiliary output, and the spread-spectrum enable. The device can therefore run without any software setup.

A simple register write port stands in for the serial management side. Each field has its own address. The first write to a field sets a sticky "written" flag, and from then on the register value replaces the latched pin value. A registered read port returns four bytes: the effective configuration, the raw latched pins, the written flags and the decoded mode.

The frequency code is decoded into one-hot mode flags: normal (100/133/166/200 MHz), reserved vendor test, bypass (outputs derived from the reference input) and board-test tri-state. In bypass mode a flag tells the divider logic whether the switchable group runs at reference/3 (66 MHz select) or reference/6. The controller is a two-state machine. `ST_CAPTURE` is entered on reset. The transition `capture_done` moves it to `ST_ACTIVE` on the first clock after reset release, and it stays in `ST_ACTIVE` until the next reset.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: While reset is asserted, `cfg_valid` and `rd_valid` are 0. The written flags are cleared. `cfg_valid` rises on the first clock edge after reset release, which is the edge where the pins are latched.
- R2: Pins are latched only on the capture edge. Later pin changes alter neither the raw byte nor the effective configuration.
- R3: Read address 1 returns the raw latched pins: bits [2:0] frequency pins, bit 3 group-select pin (active low), bit 4 aux-select pin (active low), bit 5 spread pin, bits [7:6] zero.
- R4: Read address 0 returns the effective configuration: bits [2:0] frequency code, bit 3 = 1 for a 66 MHz group, bit 4 = 1 for a 48 MHz aux clock, bit 5 = spread enable, bits [7:6] zero. Without overrides: group pin low gives 66 MHz, aux pin low gives 48 MHz, and spread follows its pin.
- R5: In `ST_ACTIVE`, a write to address 0 sets the frequency code from `wr_data[2:0]`. Address 1 sets group-66 from `wr_data[0]`, address 2 sets aux-48 from `wr_data[0]`, and address 3 sets spread from `wr_data[0]`. The effective value changes on the clock after the write, and upper data bits are ignored.
- R6: Read address 2 returns the written flags in bits [3:0], one per field address. A flag is set by a write and never clears before reset.
- R7: A write presented in `ST_CAPTURE` (the cycle right after reset release) is ignored.
- R8: Mode flags are one-hot. Codes 1xx give normal, 011 and 010 give reserved, 001 gives bypass and 000 gives tri-state. Read address 3 returns bits {tristate, bypass, reserved, normal} in [3:0].
- R9: `grp_div3` is 1 only in bypass mode with the group at 66 MHz. Otherwise it is 0, and PCI outputs use reference/6.
- R10: A read request with `rd_en` high returns `rd_data` with `rd_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_fsel | input | 3 | Frequency code strap pins |
| pin_grp_sel_n | input | 1 | Group select strap, low = 66 MHz |
| pin_aux_sel_n | input | 1 | Aux select strap, low = 48 MHz |
| pin_spread | input | 1 | Spread enable strap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Field address for a write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read byte select |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| cfg_valid | output | 1 | Configuration captured and active |
| eff_fsel | output | 3 | Effective frequency code |
| eff_grp66 | output | 1 | Group runs at 66 MHz |
| eff_aux48 | output | 1 | Aux clock is 48 MHz |
| eff_spread | output | 1 | Spread spectrum enabled |
| mode_normal | output | 1 | Normal frequency mode |
| mode_reserved | output | 1 | Reserved vendor test mode |
| mode_bypass | output | 1 | Bypass mode |
| mode_tristate | output | 1 | Tri-state board test mode |
| grp_div3 | output | 1 | Bypass group divider is 3 rather than 6 |

## Verification
A wrong latch enable would show as a raw or effective byte that tracks the pins after capture. This appears on the first read following a pin change. A written flag that is lost or set early flips the effective field between strap and register value one clock after the faulty edge, and address 2 exposes the flag directly. Decode faults show on the mode flags in the same cycle that the code settles, so every code class is visited through writes.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
    localparam int FSEL_W  = 3;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NFIELDS = 4;

    localparam logic [ADDR_W-1:0] A_FSEL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_GRP    = 2'd1;
    localparam logic [ADDR_W-1:0] A_AUX    = 2'd2;
    localparam logic [ADDR_W-1:0] A_SPREAD = 2'd3;

    typedef enum logic [0:0] {
        ST_CAPTURE = 1'b0,
        ST_ACTIVE  = 1'b1
    } ctrl_state_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic [FSEL_W-1:0] pin_fsel,
    input  logic              pin_grp_sel_n,
    input  logic              pin_aux_sel_n,
    input  logic              pin_spread,
    output logic [FSEL_W-1:0] raw_fsel,
    output logic              raw_grp_n,
    output logic              raw_aux_n,
    output logic              raw_spread
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_fsel   <= '1;
            raw_grp_n  <= 1'b1;
            raw_aux_n  <= 1'b1;
            raw_spread <= 1'b1;
        end else if (capture_en) begin
            raw_fsel   <= pin_fsel;
            raw_grp_n  <= pin_grp_sel_n;
            raw_aux_n  <= pin_aux_sel_n;
            raw_spread <= pin_spread;
        end
    end

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable({raw_fsel, raw_grp_n, raw_aux_n, raw_spread}));
endmodule

// File: rtl/cfg_override.sv
module cfg_override
    import strap_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [FSEL_W-1:0]  strap_fsel,
    input  logic               strap_grp66,
    input  logic               strap_aux48,
    input  logic               strap_spread,
    output logic [FSEL_W-1:0]  eff_fsel,
    output logic               eff_grp66,
    output logic               eff_aux48,
    output logic               eff_spread,
    output logic [NFIELDS-1:0] written
);
    logic [FSEL_W-1:0]  reg_fsel;
    logic [NFIELDS-1:1] reg_bit;
    logic [NFIELDS-1:0] written_q;

    genvar gi;
    generate
        for (gi = 0; gi < NFIELDS; gi++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    written_q[gi] <= 1'b0;
                else if (wr_ok && wr_addr == ADDR_W'(gi))
                    written_q[gi] <= 1'b1;
            end
            // R6
            flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$fell(written_q[gi]));
        end
        for (gi = 1; gi < NFIELDS; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    reg_bit[gi] <= 1'b0;
                else if (wr_ok && wr_addr == ADDR_W'(gi))
                    reg_bit[gi] <= wr_data[0];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_fsel <= '0;
        else if (wr_ok && wr_addr == A_FSEL)
            reg_fsel <= wr_data[FSEL_W-1:0];
    end

    always_comb begin
        eff_fsel   = written_q[A_FSEL]   ? reg_fsel          : strap_fsel;
        eff_grp66  = written_q[A_GRP]    ? reg_bit[A_GRP]    : strap_grp66;
        eff_aux48  = written_q[A_AUX]    ? reg_bit[A_AUX]    : strap_aux48;
        eff_spread = written_q[A_SPREAD] ? reg_bit[A_SPREAD] : strap_spread;
        written    = written_q;
    end

    // R5
    fsel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_addr == A_FSEL) |=> eff_fsel == $past(wr_data[FSEL_W-1:0]));
    // R5
    spread_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_addr == A_SPREAD) |=> eff_spread == $past(wr_data[0]));
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import strap_cfg_pkg::*;
(
    input  logic [FSEL_W-1:0] fsel,
    input  logic              grp66,
    output logic              m_normal,
    output logic              m_reserved,
    output logic              m_bypass,
    output logic              m_tristate,
    output logic              div3
);
    always_comb begin
        m_normal   = 1'b0;
        m_reserved = 1'b0;
        m_bypass   = 1'b0;
        m_tristate = 1'b0;
        if (fsel[FSEL_W-1])
            m_normal = 1'b1;
        else if (fsel[FSEL_W-2])
            m_reserved = 1'b1;
        else if (fsel[0])
            m_bypass = 1'b1;
        else
            m_tristate = 1'b1;
        div3 = m_bypass & grp66;
    end
endmodule

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
    import strap_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] pin_fsel,
    input  logic              pin_grp_sel_n,
    input  logic              pin_aux_sel_n,
    input  logic              pin_spread,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              cfg_valid,
    output logic [FSEL_W-1:0] eff_fsel,
    output logic              eff_grp66,
    output logic              eff_aux48,
    output logic              eff_spread,
    output logic              mode_normal,
    output logic              mode_reserved,
    output logic              mode_bypass,
    output logic              mode_tristate,
    output logic              grp_div3
);
    localparam int PAD_W = DATA_W - FSEL_W - 3;

    ctrl_state_t state_q, state_d;
    logic capture_en, wr_ok;
    logic [FSEL_W-1:0]  raw_fsel;
    logic               raw_grp_n, raw_aux_n, raw_spread;
    logic [NFIELDS-1:0] written;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CAPTURE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        capture_en = 1'b0;
        wr_ok      = 1'b0;
        cfg_valid  = 1'b0;
        unique case (state_q)
            ST_CAPTURE: begin
                capture_en = 1'b1;
                state_d    = ST_ACTIVE;   // capture_done
            end
            ST_ACTIVE: begin
                cfg_valid = 1'b1;
                wr_ok     = wr_en;
            end
            default: state_d = ST_CAPTURE;
        endcase
    end

    strap_capture cap_i (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en),
        .pin_fsel(pin_fsel), .pin_grp_sel_n(pin_grp_sel_n),
        .pin_aux_sel_n(pin_aux_sel_n), .pin_spread(pin_spread),
        .raw_fsel(raw_fsel), .raw_grp_n(raw_grp_n),
        .raw_aux_n(raw_aux_n), .raw_spread(raw_spread)
    );

    cfg_override ovr_i (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_addr(wr_addr), .wr_data(wr_data),
        .strap_fsel(raw_fsel), .strap_grp66(~raw_grp_n),
        .strap_aux48(~raw_aux_n), .strap_spread(raw_spread),
        .eff_fsel(eff_fsel), .eff_grp66(eff_grp66),
        .eff_aux48(eff_aux48), .eff_spread(eff_spread), .written(written)
    );

    mode_decode dec_i (
        .fsel(eff_fsel), .grp66(eff_grp66),
        .m_normal(mode_normal), .m_reserved(mode_reserved),
        .m_bypass(mode_bypass), .m_tristate(mode_tristate), .div3(grp_div3)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                unique case (rd_addr)
                    2'd0: rd_data <= {PAD_W'(0), eff_spread, eff_aux48, eff_grp66, eff_fsel};
                    2'd1: rd_data <= {PAD_W'(0), raw_spread, raw_aux_n, raw_grp_n, raw_fsel};
                    2'd2: rd_data <= {(DATA_W-NFIELDS)'(0), written};
                    default: rd_data <= {(DATA_W-4)'(0), mode_tristate, mode_bypass,
                                         mode_reserved, mode_normal};
                endcase
            end
        end
    end

    // R8
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_normal, mode_reserved, mode_bypass, mode_tristate}) == 1);
    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R1
    valid_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_valid);
    // R9
    div3_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_div3 |-> (eff_fsel == 3'b001));
endmodule

// File: tb/strap_cfg_ctrl_tb.sv
module strap_cfg_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] pin_fsel = 3'b111;
    logic pin_grp_sel_n = 1'b1, pin_aux_sel_n = 1'b1, pin_spread = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic rd_valid, cfg_valid, eff_grp66, eff_aux48, eff_spread;
    logic mode_normal, mode_reserved, mode_bypass, mode_tristate, grp_div3;
    logic [2:0] eff_fsel;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    strap_cfg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_fsel(pin_fsel), .pin_grp_sel_n(pin_grp_sel_n),
        .pin_aux_sel_n(pin_aux_sel_n), .pin_spread(pin_spread),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .cfg_valid(cfg_valid), .eff_fsel(eff_fsel), .eff_grp66(eff_grp66),
        .eff_aux48(eff_aux48), .eff_spread(eff_spread),
        .mode_normal(mode_normal), .mode_reserved(mode_reserved),
        .mode_bypass(mode_bypass), .mode_tristate(mode_tristate), .grp_div3(grp_div3)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check(rd_data, 8'hxx, "R10 unexpected read");
            else check(rd_data, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] mode_byte();
        return {4'b0, mode_tristate, mode_bypass, mode_reserved, mode_normal};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // strap 110, group low (66), aux high (24), spread high
        pin_fsel = 3'b110; pin_grp_sel_n = 1'b0; pin_aux_sel_n = 1'b1; pin_spread = 1'b1;
        repeat (3) @(negedge clk);
        check({7'b0, cfg_valid}, 8'h00, "R1 cfg_valid in reset");
        check({7'b0, rd_valid}, 8'h00, "R1 rd_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check({7'b0, cfg_valid}, 8'h01, "R1 cfg_valid after capture edge");
        rd(2'd0, 8'h2E, "R4 effective from straps");
        rd(2'd1, 8'h36, "R3 raw straps");
        rd(2'd2, 8'h00, "R1 R6 written flags clear");
        check(mode_byte(), 8'h01, "R8 normal for 110");
        check({7'b0, grp_div3}, 8'h00, "R9 no div3 outside bypass");

        // R2: pins change after capture
        pin_fsel = 3'b001; pin_grp_sel_n = 1'b1; pin_aux_sel_n = 1'b0; pin_spread = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd1, 8'h36, "R2 raw unchanged");
        rd(2'd0, 8'h2E, "R2 effective unchanged");

        wr(2'd0, 8'h01);
        check({5'b0, eff_fsel}, 8'h01, "R5 fsel written");
        check(mode_byte(), 8'h04, "R8 bypass for 001");
        check({7'b0, grp_div3}, 8'h01, "R9 div3 bypass 66");
        rd(2'd0, 8'h29, "R5 effective after fsel write");
        rd(2'd2, 8'h01, "R6 fsel flag");

        wr(2'd1, 8'h00);
        check({7'b0, grp_div3}, 8'h00, "R9 div6 bypass 33");
        rd(2'd0, 8'h21, "R5 group override");

        wr(2'd0, 8'h03);
        check(mode_byte(), 8'h02, "R8 reserved 011");
        wr(2'd0, 8'h02);
        check(mode_byte(), 8'h02, "R8 reserved 010");
        rd(2'd3, 8'h02, "R8 mode byte read");
        wr(2'd0, 8'h00);
        check(mode_byte(), 8'h08, "R8 tristate 000");
        wr(2'd0, 8'h04);
        check(mode_byte(), 8'h01, "R8 normal 100");

        wr(2'd2, 8'h01);
        wr(2'd3, 8'h00);
        check({7'b0, eff_spread}, 8'h00, "R5 spread off");
        rd(2'd0, 8'h14, "R5 aux and spread override");
        rd(2'd2, 8'h0F, "R6 all flags");

        wr(2'd0, 8'hFF);
        rd(2'd0, 8'h17, "R5 upper bits ignored");
        rd(2'd3, 8'h01, "R8 mode byte normal");

        // second reset, write in capture cycle must be ignored
        rst_n = 1'b0;
        pin_fsel = 3'b101; pin_grp_sel_n = 1'b1; pin_aux_sel_n = 1'b0; pin_spread = 1'b0;
        repeat (2) @(negedge clk);
        rd_en = 1'b0;
        rst_n = 1'b1;
        wr(2'd0, 8'h00);
        rd(2'd2, 8'h00, "R7 R1 flags after capture-cycle write");
        rd(2'd0, 8'h15, "R7 R4 effective after reset");
        rd(2'd1, 8'h0D, "R3 raw second strap set");
        check(mode_byte(), 8'h01, "R8 normal for 101");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check(8'(exp_q.size()), 8'h00, "R10 reads outstanding");
        finish_run();
    end
endmodule